// File: doc/BRIEF.md
# Parallel Printer Port Host Registers

This block is the host-facing register file of a PC-style parallel printer port. It sits on a simple strobed host bus made of an address, a write data byte, an active-low write strobe and an active-low read strobe. It decodes three byte locations above a base address. The output-data register sits at offset 0 and drives the eight printer data pins. The printer-status register at offset 1 maps the printer's status lines into a byte. The printer-control register at offset 2 drives six control lines.

A status read is captured once, when the read strobe falls, and that captured byte is held for the rest of the strobe. Bit 0 of the status byte is a bus-timeout flag. It is meaningful only when the port runs in its enhanced (EPP) bus mode, where it reports an enhanced bus cycle that has stayed open for longer than a fixed time, 10 ms by default. The host clears the flag by writing a one to it.

All strobes are sampled on the block clock. A write takes effect on the clock edge that first sees the write strobe high again, using the address and data held while the strobe was low.

Top module: `lpt_regs`

## Requirements
- R1: Writing offset 0 loads the byte into the data register, which drives pd_o without inversion from the clock edge that first sees wr_ni high after a low phase; reset clears it to 0x00.
- R2: Reading offset 0 returns the live level of pd_i, not the data register.
- R3: The status byte is captured on the clock edge that first sees rd_ni low and stays unchanged until rd_ni returns high, even if the printer inputs change meanwhile.
- R4: The status byte layout is bit 7 = inverse of prn_busy_i, bit 6 = prn_ack_ni, bit 5 = prn_paper_out_i, bit 4 = prn_online_i, bit 3 = prn_fault_ni, bits 2 and 1 = 0, bit 0 = timeout flag.
- R5: With epp_mode_i high, the timeout flag sets once epp_cyc_i has been held high for TERM consecutive clocks (TERM = CLK_HZ/1000*TMO_MS). A low epp_cyc_i restarts the count.
- R6: Writing offset 1 with bit 0 = 1 clears the timeout flag. Writing bit 0 = 0 leaves it unchanged, and reset clears it.
- R7: While epp_mode_i is low the timeout flag reads 0.
- R8: Writing offset 2 stores bits 5:0 into ctrl_o. Reset loads CTRL_RST (default 0x04). Reading offset 2 returns {2'b00, ctrl_o}.
- R9: Writes to any address other than BASE..BASE+2 change nothing, and reads there return 0x00. rdata_o is 0x00 whenever rd_ni is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | 8 | Host write data |
| wr_ni | input | 1 | Host write strobe, active low |
| rd_ni | input | 1 | Host read strobe, active low |
| rdata_o | output | 8 | Host read data, valid while rd_ni is low |
| pd_o | output | 8 | Printer data pins, driven from the data register |
| pd_i | input | 8 | Printer data pin levels |
| ctrl_o | output | 6 | Control register bits 5:0 |
| prn_busy_i | input | 1 | Printer busy, active high |
| prn_ack_ni | input | 1 | Printer acknowledge, active low |
| prn_paper_out_i | input | 1 | Paper end |
| prn_online_i | input | 1 | Printer selected / on line |
| prn_fault_ni | input | 1 | Printer error, active low |
| epp_mode_i | input | 1 | 1 selects the enhanced bus mode, 0 selects standard mode |
| epp_cyc_i | input | 1 | An enhanced bus cycle is in progress |

## Verification
The assertions assume that the strobes and the address are synchronous to clk_i. They also assume that a strobe, once low, stays low for at least one full clock with a stable address, so that the edge detectors see every transition. The bench drives every bus input at the falling clock edge and holds each strobe low for at least one whole period. It never raises both strobes in the same cycle, and it keeps epp_cyc_i low while it clears the flag. The timeout is shortened through the CLK_HZ parameter so that the terminal count falls within a short run.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    OFS_DATA = 2'd0,
    OFS_STAT = 2'd1,
    OFS_CTRL = 2'd2,
    OFS_NONE = 2'd3
  } ofs_e;

  typedef struct packed {
    logic busy;
    logic ack_n;
    logic paper_out;
    logic online;
    logic fault_n;
  } prn_stat_t;

  function automatic logic [DW-1:0] pack_status(prn_stat_t s, logic tmo);
    return {~s.busy, s.ack_n, s.paper_out, s.online, s.fault_n, 2'b00, tmo};
  endfunction
endpackage

// File: rtl/lpt_host_if.sv
module lpt_host_if
  import lpt_pkg::*;
#(
  parameter int          ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h378
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wr_ni,
  input  logic              rd_ni,
  output logic              wr_stb_o,
  output ofs_e              wr_ofs_o,
  output logic [DW-1:0]     wr_data_o,
  output logic              rd_fall_o,
  output logic              rd_held_o,
  output ofs_e              rd_ofs_o
);
  logic              wr_q, rd_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DW-1:0]     wd_q;

  function automatic ofs_e decode(logic [ADDR_W-1:0] a);
    if (a == BASE)                        return OFS_DATA;
    else if (a == BASE + ADDR_W'(1))      return OFS_STAT;
    else if (a == BASE + ADDR_W'(2))      return OFS_CTRL;
    else                                  return OFS_NONE;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
      wa_q <= '0;
      wd_q <= '0;
    end else begin
      wr_q <= wr_ni;
      rd_q <= rd_ni;
      if (!wr_ni) begin
        wa_q <= addr_i;
        wd_q <= wdata_i;
      end
    end
  end

  // write commits on the strobe's trailing (rising) edge
  assign wr_stb_o  = wr_ni & ~wr_q;
  assign wr_ofs_o  = decode(wa_q);
  assign wr_data_o = wd_q;
  assign rd_fall_o = ~rd_ni & rd_q;
  assign rd_held_o = ~rd_ni & ~rd_q;
  assign rd_ofs_o  = decode(addr_i);

  p_one_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fall_o |=> !rd_fall_o);
endmodule

// File: rtl/lpt_tmo.sv
module lpt_tmo #(
  parameter int TERM = 1250000,
  localparam int CW  = $clog2(TERM + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic epp_mode_i,
  input  logic epp_cyc_i,
  input  logic clr_i,
  output logic flag_o
);
  logic [CW-1:0] cnt_q;
  logic          active, at_term;

  assign active  = epp_mode_i & epp_cyc_i;
  assign at_term = (cnt_q == CW'(TERM - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (!at_term) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // clear beats a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            flag_o <= 1'b0;
    else if (!epp_mode_i)   flag_o <= 1'b0;
    else if (clr_i)         flag_o <= 1'b0;
    else if (active && at_term) flag_o <= 1'b1;
  end

  p_spp_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epp_mode_i |=> !flag_o);
  p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !flag_o);
  p_set_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && epp_mode_i && !clr_i && !(epp_cyc_i && at_term)) |=> !flag_o);
endmodule

// File: rtl/lpt_status.sv
module lpt_status
  import lpt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_fall_i,
  input  logic          rd_held_i,
  input  prn_stat_t     stat_i,
  input  logic          tmo_i,
  output logic [DW-1:0] snap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_o <= '0;
    else if (rd_fall_i) snap_o <= pack_status(stat_i, tmo_i);
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_held_i |=> $stable(snap_o));
  p_ready_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fall_i |=> (snap_o[7] == !$past(stat_i.busy)) && (snap_o[2:1] == 2'b00));
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h378,
  parameter int          CLK_HZ   = 125000000,
  parameter int          TMO_MS   = 10,
  parameter logic [5:0]  CTRL_RST = 6'h04,
  localparam int         TERM     = (CLK_HZ / 1000) * TMO_MS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_ni,
  input  logic              rd_ni,
  output logic [7:0]        rdata_o,
  output logic [7:0]        pd_o,
  input  logic [7:0]        pd_i,
  output logic [5:0]        ctrl_o,
  input  logic              prn_busy_i,
  input  logic              prn_ack_ni,
  input  logic              prn_paper_out_i,
  input  logic              prn_online_i,
  input  logic              prn_fault_ni,
  input  logic              epp_mode_i,
  input  logic              epp_cyc_i
);
  logic          wr_stb, rd_fall, rd_held, tmo_flag, tmo_clr;
  ofs_e          wr_ofs, rd_ofs;
  logic [DW-1:0] wr_data, snap;
  prn_stat_t     stat;

  assign stat = '{busy: prn_busy_i, ack_n: prn_ack_ni, paper_out: prn_paper_out_i,
                  online: prn_online_i, fault_n: prn_fault_ni};

  lpt_host_if #(.ADDR_W(ADDR_W), .BASE(BASE)) u_host (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_ni, .rd_ni,
    .wr_stb_o(wr_stb), .wr_ofs_o(wr_ofs), .wr_data_o(wr_data),
    .rd_fall_o(rd_fall), .rd_held_o(rd_held), .rd_ofs_o(rd_ofs)
  );

  assign tmo_clr = wr_stb && (wr_ofs == OFS_STAT) && wr_data[0];

  lpt_tmo #(.TERM(TERM)) u_tmo (
    .clk_i, .rst_ni, .epp_mode_i, .epp_cyc_i,
    .clr_i(tmo_clr), .flag_o(tmo_flag)
  );

  lpt_status u_stat (
    .clk_i, .rst_ni, .rd_fall_i(rd_fall), .rd_held_i(rd_held),
    .stat_i(stat), .tmo_i(tmo_flag), .snap_o(snap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_o   <= '0;
      ctrl_o <= CTRL_RST;
    end else if (wr_stb) begin
      if (wr_ofs == OFS_DATA) pd_o   <= wr_data;
      if (wr_ofs == OFS_CTRL) ctrl_o <= wr_data[5:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!rd_ni) begin
      unique case (rd_ofs)
        OFS_DATA: rdata_o = pd_i;
        OFS_STAT: rdata_o = snap;
        OFS_CTRL: rdata_o = {2'b00, ctrl_o};
        default:  rdata_o = '0;
      endcase
    end
  end

  p_data_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && wr_ofs == OFS_DATA) |=> pd_o == $past(wr_data));
  p_ctrl_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && wr_ofs == OFS_CTRL) |=> ctrl_o == $past(wr_data[5:0]));
  p_unmapped_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && wr_ofs == OFS_NONE) |=> $stable(pd_o) && $stable(ctrl_o));
  p_idle_rdata_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni |-> rdata_o == 8'h00);
endmodule

// File: tb/sim_lpt_regs.sv
module sim_lpt_regs;
  localparam int          AW   = 10;
  localparam logic [9:0]  BASE = 10'h378;
  localparam int          TERM = 2000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic [7:0] wdata = '0, pd_in = '0;
  logic       wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] rdata, pd_out;
  logic [5:0] ctrl;
  logic       busy = 0, ack_n = 1, pout = 0, online = 1, fault_n = 1;
  logic       epp_mode = 0, epp_cyc = 0;
  int         n_chk = 0, n_err = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  lpt_regs #(.ADDR_W(AW), .BASE(BASE), .CLK_HZ(200000), .TMO_MS(10)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_ni(wr_n),
    .rd_ni(rd_n), .rdata_o(rdata), .pd_o(pd_out), .pd_i(pd_in), .ctrl_o(ctrl),
    .prn_busy_i(busy), .prn_ack_ni(ack_n), .prn_paper_out_i(pout),
    .prn_online_i(online), .prn_fault_ni(fault_n),
    .epp_mode_i(epp_mode), .epp_cyc_i(epp_cyc)
  );

  // {wdata[20:13], busy,ack_n,pout,online,fault_n [12:8], expected status [7:0]}
  localparam logic [20:0] VEC [8] = '{
    {8'hA5, 5'b00000, 8'h80}, {8'h5A, 5'b11111, 8'h78},
    {8'hFF, 5'b10000, 8'h00}, {8'h00, 5'b01000, 8'hC0},
    {8'h3C, 5'b00100, 8'hA0}, {8'hC3, 5'b00010, 8'h90},
    {8'h81, 5'b00001, 8'h88}, {8'h7E, 5'b10101, 8'h28}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [9:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic bus_rd(logic [9:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_n = 1'b0;
    @(negedge clk); @(negedge clk); d = rdata;
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_cyc(int n);
    @(negedge clk); epp_cyc = 1'b1;
    repeat (n) @(negedge clk);
    epp_cyc = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset data", pd_out, 8'h00);
    chk("R8 reset ctrl", {2'b00, ctrl}, 8'h04);
    chk("R9 idle rdata", rdata, 8'h00);

    // table walk: data output and status mapping
    for (int i = 0; i < 8; i++) begin
      bus_wr(BASE, VEC[i][20:13]);
      chk("R1 data out", pd_out, VEC[i][20:13]);
      {busy, ack_n, pout, online, fault_n} = VEC[i][12:8];
      bus_rd(BASE + 10'd1, r);
      chk("R4 status map", r, VEC[i][7:0]);
    end

    // R2 live pin read
    pd_in = 8'h96;
    bus_rd(BASE, r);
    chk("R2 live pins", r, 8'h96);

    // R3 hold during strobe
    {busy, ack_n, pout, online, fault_n} = 5'b00000;
    @(negedge clk); addr = BASE + 10'd1; rd_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 captured", rdata, 8'h80);
    {busy, ack_n, pout, online, fault_n} = 5'b11111;
    repeat (3) @(negedge clk);
    chk("R3 held", rdata, 8'h80);
    rd_n = 1'b1;
    @(negedge clk);
    bus_rd(BASE + 10'd1, r);
    chk("R3 recaptured", r, 8'h78);

    // R8 control
    bus_wr(BASE + 10'd2, 8'hFF);
    chk("R8 ctrl pins", {2'b00, ctrl}, 8'h3F);
    bus_rd(BASE + 10'd2, r);
    chk("R8 ctrl read", r, 8'h3F);
    bus_wr(BASE + 10'd2, 8'h12);
    chk("R8 ctrl write", {2'b00, ctrl}, 8'h12);

    // R9 unmapped
    bus_wr(BASE + 10'd3, 8'h11);
    bus_wr(BASE - 10'd1, 8'h22);
    chk("R9 data untouched", pd_out, 8'h7E);
    chk("R9 ctrl untouched", {2'b00, ctrl}, 8'h12);
    bus_rd(BASE + 10'd3, r);
    chk("R9 read zero", r, 8'h00);

    // timeout in enhanced mode
    epp_mode = 1'b1;
    run_cyc(TERM - 10);
    bus_rd(BASE + 10'd1, r);
    chk("R5 below term", {7'd0, r[0]}, 8'h00);
    run_cyc(TERM - 10);
    bus_rd(BASE + 10'd1, r);
    chk("R5 count restarts", {7'd0, r[0]}, 8'h00);
    run_cyc(TERM + 5);
    bus_rd(BASE + 10'd1, r);
    chk("R5 flag set", r, 8'h79);

    bus_wr(BASE + 10'd1, 8'hFE);
    bus_rd(BASE + 10'd1, r);
    chk("R6 write zero keeps", {7'd0, r[0]}, 8'h01);
    bus_wr(BASE + 10'd1, 8'h01);
    bus_rd(BASE + 10'd1, r);
    chk("R6 write one clears", {7'd0, r[0]}, 8'h00);

    run_cyc(TERM + 5);
    bus_rd(BASE + 10'd1, r);
    chk("R5 set again", {7'd0, r[0]}, 8'h01);
    epp_mode = 1'b0;
    @(negedge clk);
    bus_rd(BASE + 10'd1, r);
    chk("R7 standard mode zero", {7'd0, r[0]}, 8'h00);
    run_cyc(TERM + 5);
    bus_rd(BASE + 10'd1, r);
    chk("R7 no count in standard", {7'd0, r[0]}, 8'h00);

    // reset flag clear
    epp_mode = 1'b1;
    run_cyc(TERM + 5);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears data", pd_out, 8'h00);
    chk("R8 reset restores ctrl", {2'b00, ctrl}, 8'h04);
    rst_n = 1'b1;
    @(negedge clk);
    bus_rd(BASE + 10'd1, r);
    chk("R6 reset clears flag", {7'd0, r[0]}, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule